// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block sits beside a processor core and turns writes to its command registers into a single interrupt send request toward an on-chip interrupt fabric. Software describes the interrupt (vector, destination, a destination shorthand and a physical or logical addressing flag), and the unit presents that description as one request. The request stays on a valid/ready handshake until the fabric takes it.

Two programming models are selected by a mode input. In the split model, software first writes an 8-bit destination into a high command word. It then writes a low command word, and that write launches the send. A delivery-busy flag in the low word lets software poll until the fabric has accepted the request. In the wide model, a single 64-bit write carries a 32-bit destination together with the low fields, and the busy flag always reads zero. The wide model also adds a self-interrupt register: a write to it sends the written vector to the local core.

At most one request is outstanding. A launching write that arrives while a request is still waiting is dropped, and a sticky error output records the collision.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, req_valid and send_err are 0, and reading offset 0x300 returns 0.
- R2: In split mode (ext_mode=0), a write to offset 0x310 stores bits 31:24 as the destination. A later write to offset 0x300 launches a request with vector = bits 7:0, shorthand = bits 19:18 (0 none, 1 self, 2 all, 3 all but self), logical = bit 11, and req_dest = the stored destination zero-extended. Reading 0x310 returns the stored destination in bits 31:24.
- R3: In split mode, bit 12 of a read of offset 0x300 is 1 while a request is outstanding and 0 from the cycle after the fabric accepts it.
- R4: In wide mode (ext_mode=1), one write to offset 0x300 launches a request with req_dest = bits 63:32 and the low fields placed as in R2. Bit 12 of a read of 0x300 always reads 0.
- R5: In wide mode, a write to offset 0x3F0 launches a request with vector = bits 7:0, shorthand 1 (self), logical 0 and destination 0. In split mode, the same write launches nothing.
- R6: While req_valid is high and req_ready is low, every request field stays unchanged. req_valid falls the cycle after the handshake completes, and no second request follows from the same write.
- R7: A launching write while a request is outstanding is ignored: the request fields keep their values and send_err becomes 1. send_err stays 1 until reset.
- R8: req_valid rises in the cycle after an accepted launching write.
- R9: Writes to any other offset launch nothing, and in wide mode a read of 0x310 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 0 split-register model, 1 wide model |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 64 | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 64 | Read data (combinational) |
| req_valid | output | 1 | Send request pending |
| req_ready | input | 1 | Fabric accepts the request |
| req_vector | output | 8 | Interrupt vector |
| req_dest | output | DEST_W | Destination identifier |
| req_shorthand | output | 2 | Destination shorthand |
| req_logical | output | 1 | 1 logical, 0 physical destination |
| send_err | output | 1 | Sticky collision flag |

## Verification
The hardest situation to reach is a launching write that lands while a request is still held, because a prompt fabric never leaves a request waiting. The bench keeps req_ready low after a launch and then issues a second low-word write with different contents. It checks that the visible request keeps the first command, that the error flag rises and stays set, and that accepting the request produces no second one. The table also covers every shorthand code, both addressing modes, and writes that set bit 12, which must never leak into the status.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [11:0] OFF_CMD_LO = 12'h300;
  localparam logic [11:0] OFF_CMD_HI = 12'h310;
  localparam logic [11:0] OFF_SELF   = 12'h3F0;
  localparam int unsigned VEC_W       = 8;
  localparam int unsigned LEG_ID_W    = 8;
  localparam int unsigned LEG_ID_LSB  = 24;
  localparam int unsigned STATUS_BIT  = 12;
  localparam int unsigned LOGICAL_BIT = 11;
  localparam int unsigned SH_LSB      = 18;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  function automatic logic [VEC_W-1:0] lo_vector(input logic [31:0] lo);
    return lo[VEC_W-1:0];
  endfunction

  function automatic logic [1:0] lo_short(input logic [31:0] lo);
    return lo[SH_LSB +: 2];
  endfunction

  function automatic logic lo_logical(input logic [31:0] lo);
    return lo[LOGICAL_BIT];
  endfunction

  function automatic logic [31:0] self_cmd(input logic [VEC_W-1:0] vec);
    logic [31:0] r;
    r = '0;
    r[VEC_W-1:0] = vec;
    r[SH_LSB +: 2] = SH_SELF;
    return r;
  endfunction

  function automatic logic [31:0] status_view(input logic [31:0] lo, input logic busy);
    logic [31:0] r;
    r = lo;
    r[STATUS_BIT] = busy;
    return r;
  endfunction
endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              ext_mode,
  output logic              hit_lo,
  output logic              hit_hi,
  output logic              hit_self
);
  always_comb begin
    hit_lo   = wr_en && (wr_addr == ADDR_W'(OFF_CMD_LO));
    hit_hi   = wr_en && !ext_mode && (wr_addr == ADDR_W'(OFF_CMD_HI));
    hit_self = wr_en && ext_mode && (wr_addr == ADDR_W'(OFF_SELF));
  end

  // R9: at most one register is selected by any write
  always_comb begin
    a_r9_hits_exclusive: assert ($onehot0({hit_lo, hit_hi, hit_self}));
  end
endmodule

// File: rtl/ipi_send_ctrl.sv
module ipi_send_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic req_ready,
  output logic pending,
  output logic load,
  output logic err
);
  logic collide;

  always_comb begin
    load    = launch && !pending;
    collide = launch && pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (load) pending <= 1'b1;
      else if (pending && req_ready) pending <= 1'b0;
      if (collide) err <= 1'b1;
    end
  end

  a_r8_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pending);
  a_r6_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && req_ready && !launch) |=> !pending);
  a_r7_collide_err: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> err);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/ipi_cmd_store.sv
module ipi_cmd_store
  import ipi_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              hit_hi,
  input  logic              load,
  input  logic              load_self,
  input  logic [63:0]       wr_data,
  input  logic              pending,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VEC_W-1:0]  vec,
  output logic [DEST_W-1:0] dest,
  output logic [1:0]        sh,
  output logic              logical,
  output logic [63:0]       rd_data
);
  logic [LEG_ID_W-1:0] leg_id;
  logic [31:0]         cmd_lo;
  logic [DEST_W-1:0]   cmd_dest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg_id   <= '0;
      cmd_lo   <= '0;
      cmd_dest <= '0;
    end else begin
      if (hit_hi) leg_id <= wr_data[LEG_ID_LSB +: LEG_ID_W];
      if (load) begin
        if (load_self) begin
          cmd_lo   <= self_cmd(wr_data[VEC_W-1:0]);
          cmd_dest <= '0;
        end else begin
          cmd_lo   <= wr_data[31:0];
          cmd_dest <= ext_mode ? wr_data[32 +: DEST_W] : DEST_W'(leg_id);
        end
      end
    end
  end

  always_comb begin
    vec     = lo_vector(cmd_lo);
    sh      = lo_short(cmd_lo);
    logical = lo_logical(cmd_lo);
    dest    = cmd_dest;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFF_CMD_LO)) begin
      if (ext_mode) rd_data = {32'(cmd_dest), status_view(cmd_lo, 1'b0)};
      else          rd_data = {32'd0, status_view(cmd_lo, pending)};
    end else if (rd_addr == ADDR_W'(OFF_CMD_HI) && !ext_mode) begin
      rd_data[LEG_ID_LSB +: LEG_ID_W] = leg_id;
    end
  end

  // R4: the wide model never reports a busy status
  always_comb begin
    if (ext_mode && rd_addr == ADDR_W'(OFF_CMD_LO))
      a_r4_no_status_ext: assert (rd_data[STATUS_BIT] == 1'b0);
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VEC_W-1:0]  req_vector,
  output logic [DEST_W-1:0] req_dest,
  output logic [1:0]        req_shorthand,
  output logic              req_logical,
  output logic              send_err
);
  logic hit_lo, hit_hi, hit_self;
  logic launch, load, pending;

  ipi_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .ext_mode(ext_mode),
    .hit_lo(hit_lo), .hit_hi(hit_hi), .hit_self(hit_self)
  );

  assign launch = hit_lo || hit_self;

  ipi_send_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(launch), .req_ready(req_ready),
    .pending(pending), .load(load), .err(send_err)
  );

  ipi_cmd_store #(.ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_store (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .hit_hi(hit_hi),
    .load(load), .load_self(hit_self), .wr_data(wr_data), .pending(pending),
    .rd_addr(rd_addr), .vec(req_vector), .dest(req_dest), .sh(req_shorthand),
    .logical(req_logical), .rd_data(rd_data)
  );

  assign req_valid = pending;

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vector) &&
      $stable(req_dest) && $stable(req_shorthand) && $stable(req_logical)));
  a_r5_split_self_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && wr_en && wr_addr == ADDR_W'(OFF_SELF) && !req_valid) |=> !req_valid);
  a_r3_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && rd_addr == ADDR_W'(OFF_CMD_LO)) |-> (rd_data[STATUS_BIT] == req_valid));
  a_r7_ignored_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && launch) |=> ($stable(req_vector) && $stable(req_dest)));
endmodule

// File: tb/ipi_cmd_unit_tb.sv
module ipi_cmd_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam logic [11:0] A_LO = 12'h300, A_HI = 12'h310, A_SELF = 12'h3F0;

  localparam logic        T_EXT [N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] T_HI  [N] = '{32'h2A00_0000, 32'h07FF_FFFF, 32'hFF00_0000, 32'h0, 32'h0, 32'h0};
  localparam logic [63:0] T_LO  [N] = '{64'h0000_0000_0000_0041, 64'h0000_0000_000C_08F0,
                                        64'h0000_0000_0004_1020, 64'h1234_5678_0008_0899,
                                        64'h0000_0003_000C_0001, 64'hFFFF_FFFF_0000_10FE};
  localparam logic [7:0]  E_VEC [N] = '{8'h41, 8'hF0, 8'h20, 8'h99, 8'h01, 8'hFE};
  localparam logic [31:0] E_DST [N] = '{32'h2A, 32'h07, 32'hFF, 32'h1234_5678, 32'h3, 32'hFFFF_FFFF};
  localparam logic [1:0]  E_SH  [N] = '{2'd0, 2'd3, 2'd1, 2'd2, 2'd3, 2'd0};
  localparam logic        E_LOG [N] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 0, rst_n = 0, ext_mode = 0, wr_en = 0, req_ready = 0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic req_valid, req_logical, send_err;
  logic [7:0] req_vector;
  logic [31:0] req_dest;
  logic [1:0] req_shorthand;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_vector(req_vector), .req_dest(req_dest),
    .req_shorthand(req_shorthand), .req_logical(req_logical), .send_err(send_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic accept();
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_addr = A_LO;
    @(negedge clk);
    // R1 reset state
    check(req_valid == 0, "R1 valid", req_valid, 0);
    check(send_err == 0, "R1 err", send_err, 0);
    check(rd_data == 0, "R1 readback", rd_data, 0);

    for (int i = 0; i < N; i++) begin
      ext_mode = T_EXT[i];
      if (!T_EXT[i]) wr(A_HI, {32'd0, T_HI[i]});
      wr(A_LO, T_LO[i]);
      // R8 valid the cycle after the launch; R2/R4 fields
      check(req_valid == 1, "R8 valid", req_valid, 1);
      check(req_vector == E_VEC[i], "R2/R4 vector", req_vector, E_VEC[i]);
      check(req_dest == E_DST[i], "R2/R4 dest", req_dest, E_DST[i]);
      check(req_shorthand == E_SH[i], "R2/R4 shorthand", req_shorthand, E_SH[i]);
      check(req_logical == E_LOG[i], "R2/R4 logical", req_logical, E_LOG[i]);
      rd_addr = A_LO; #1;
      check(rd_data[12] == !T_EXT[i], "R3/R4 busy bit", rd_data[12], !T_EXT[i]);
      repeat (2) @(negedge clk);
      check(req_valid && req_vector == E_VEC[i] && req_dest == E_DST[i], "R6 held",
            {req_valid, req_vector}, {1'b1, E_VEC[i]});
      accept();
      check(req_valid == 0, "R6 drop after handshake", req_valid, 0);
      #1;
      check(rd_data[12] == 0, "R3 busy clear", rd_data[12], 0);
    end

    // R7 collision while outstanding
    ext_mode = 0;
    wr(A_HI, 64'h1100_0000);
    wr(A_LO, 64'h55);
    wr(A_LO, 64'h66);
    check(req_vector == 8'h55, "R7 fields kept", req_vector, 8'h55);
    check(send_err == 1, "R7 err set", send_err, 1);
    accept();
    repeat (2) @(negedge clk);
    check(req_valid == 0, "R6 single issue", req_valid, 0);
    check(send_err == 1, "R7 err sticky", send_err, 1);
    rd_addr = A_HI; #1;
    check(rd_data == 64'h1100_0000, "R2 hi readback", rd_data, 64'h1100_0000);

    // R5 self register ignored in split mode
    wr(A_SELF, 64'h77);
    check(req_valid == 0, "R5 split self ignored", req_valid, 0);
    // R9 other offset ignored
    wr(12'h320, 64'h0000_0000_0000_0042);
    check(req_valid == 0, "R9 other offset", req_valid, 0);

    // R5 self register in wide mode
    ext_mode = 1;
    rd_addr = A_HI; #1;
    check(rd_data == 0, "R9 hi read in wide", rd_data, 0);
    wr(A_SELF, 64'h1234_0000_000C_08A5);
    check(req_valid == 1, "R5 self valid", req_valid, 1);
    check(req_vector == 8'hA5, "R5 self vector", req_vector, 8'hA5);
    check(req_shorthand == 2'd1, "R5 self shorthand", req_shorthand, 2'd1);
    check(req_dest == 0 && req_logical == 0, "R5 self dest/mode", {req_dest, req_logical}, 0);
    accept();
    check(req_valid == 0, "R6 self drop", req_valid, 0);
    wr(12'h310, 64'hFFFF_FFFF_FFFF_FFFF);
    check(req_valid == 0, "R9 wide hi write", req_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule